// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the sleep states of a small 8-bit microcontroller core. Software sets one of two request bits in a control register: a light sleep, where only the CPU clock stops, or a deep sleep, where the oscillator enable is also dropped. The controller gates the CPU and peripheral clock enables, watches the interrupt lines with their enable and level-sensitivity flags, and brings the core back to run. After a deep-sleep wake it holds the CPU clock off for a fixed oscillator-settling count. It also handles the external reset pin and sets the external bus-control pins and port output modes while the core sleeps.

The controller runs from an always-on clock that is independent of the oscillator enable it produces. The reset pin input `hw_rst` is assumed to be synchronised already. `rst` resets only the controller itself. When the reset pin ends a light sleep, the core may run for a short window before its reset is applied. During that window internal RAM writes are blocked, while port writes are not.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst`, the state is run: `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, both request bits are 0, `core_rst_o` and `ram_wr_blk` are 0, and all mode outputs are 0.
- R2: In run with `hw_rst` low, `ctl_we` loads `ctl_idle_d`/`ctl_pd_d` into the request bits at the next edge. The CPU clock stays on for that cycle and the sleep state starts at the edge after.
- R3: In light sleep, `cpu_clk_en`=0 while `periph_clk_en`=1 and `osc_en`=1.
- R4: Light sleep ends at the next edge when any line has both `irq_pend` and `irq_en` set. A pending line that is not enabled has no effect. On exit both request bits read 0.
- R5: In deep sleep, `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R6: With both request bits set, deep sleep is entered, not light sleep.
- R7: Deep sleep is left by an interrupt only on an external line (indices below N_EXT) that is pending and enabled, and whose `irq_level` flag was 1 at the entry edge. Internal lines, lines that were edge-configured at entry, and level flags changed during sleep do not wake it.
- R8: After a deep-sleep interrupt wake, `osc_en` is 1 from the next cycle, and `cpu_clk_en` stays 0 for exactly SETTLE_CYC cycles before run resumes with both request bits 0.
- R9: If `hw_rst` rises in light sleep, the core runs for exactly GRACE_CYC cycles with `cpu_clk_en`=1, `ram_wr_blk`=1 and `core_rst_o`=0. Then the state is run, with both request bits 0, and `core_rst_o` is 1 while `hw_rst` stays high.
- R10: `hw_rst` in deep sleep or during settling returns to run at the next edge with `osc_en`=1 and both request bits 0, and `core_rst_o` is 1 while `hw_rst` is high.
- R11: In light sleep, `ale_o`=`psen_o`=1 and `p13_mode`=1 (hold). `p0_mode` is 2 (float) if `ext_prog` else 1, and `p2_mode` is 3 (address) if `ext_prog` else 1.
- R12: In deep sleep and settling, `ale_o`=`psen_o`=0 and `p2_mode`=`p13_mode`=1. `p0_mode` is 2 if `ext_prog` else 1.
- R13: While the CPU clock runs, `ale_o`/`psen_o` follow `core_ale`/`core_psen` and all mode outputs are 0 (core control).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high controller reset |
| hw_rst | input | 1 | Synchronised external reset pin |
| ctl_we | input | 1 | Control register write strobe |
| ctl_idle_d | input | 1 | Light-sleep request bit write data |
| ctl_pd_d | input | 1 | Deep-sleep request bit write data |
| ctl_idle_q | output | 1 | Light-sleep request bit |
| ctl_pd_q | output | 1 | Deep-sleep request bit |
| irq_pend | input | N_IRQ | Interrupt pending flags, external lines first |
| irq_en | input | N_IRQ | Interrupt enable flags |
| irq_level | input | N_EXT | Level-sensitive flags of the external lines |
| ext_prog | input | 1 | Code runs from external program memory |
| core_ale | input | 1 | Address-latch strobe from the core |
| core_psen | input | 1 | Program-read strobe from the core |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Reset to the core |
| ram_wr_blk | output | 1 | Blocks internal RAM writes |
| ale_o | output | 1 | Address-latch pin level |
| psen_o | output | 1 | Program-read pin level |
| p0_mode | output | 2 | Port 0 mode: 0 core, 1 hold, 2 float, 3 address |
| p2_mode | output | 2 | Port 2 mode, same encoding |
| p13_mode | output | 2 | Ports 1 and 3 mode, same encoding |

## Verification
The assertions assume that `hw_rst` stays high once it has risen, until the grace window ends and the core reset has been seen. They also assume that the CPU does not write the control register outside run. Stimulus respects both assumptions: the reset pin is raised only for a held pulse, and request writes are made only while the CPU clock runs. Interrupt pending, enable and level vectors are drawn at random within these limits. Wake decisions are predicted from the level flags captured at entry.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_GRACE  = 3'd2,
        ST_PDOWN  = 3'd3,
        ST_SETTLE = 3'd4
    } lpm_state_e;

    typedef enum logic [1:0] {
        PM_CORE  = 2'd0,
        PM_HOLD  = 2'd1,
        PM_FLOAT = 2'd2,
        PM_ADDR  = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic      ale;
        logic      psen;
        pin_mode_e p0;
        pin_mode_e p2;
        pin_mode_e p13;
    } pin_ctl_t;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic osc;
    } clk_ctl_t;

    function automatic clk_ctl_t clocks_for(lpm_state_e s);
        clk_ctl_t c;
        c.cpu    = (s == ST_RUN) || (s == ST_GRACE);
        c.periph = (s == ST_RUN) || (s == ST_GRACE) || (s == ST_IDLE);
        c.osc    = (s != ST_PDOWN);
        return c;
    endfunction

    function automatic pin_ctl_t sleep_pins(logic deep, logic ext);
        pin_ctl_t p;
        p.ale  = !deep;
        p.psen = !deep;
        p.p0   = ext ? PM_FLOAT : PM_HOLD;
        p.p2   = (ext && !deep) ? PM_ADDR : PM_HOLD;
        p.p13  = PM_HOLD;
        return p;
    endfunction

endpackage

// File: rtl/lpm_timer.sv
module lpm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
    parameter int N_IRQ = 6,
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch_lvl,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_EXT-1:0] irq_level,
    output logic             any_wake,
    output logic             ext_wake
);
    logic [N_EXT-1:0] lvl_at_entry;
    logic [N_EXT-1:0] ext_hit;

    always_ff @(posedge clk) begin
        if (rst)
            lvl_at_entry <= '0;
        else if (latch_lvl)
            lvl_at_entry <= irq_level;
    end

    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        assign ext_hit[i] = irq_pend[i] & irq_en[i] & lvl_at_entry[i];
    end

    assign any_wake = |(irq_pend & irq_en);
    assign ext_wake = |ext_hit;
endmodule

// File: rtl/lpm_pins.sv
module lpm_pins
    import lpm_pkg::*;
(
    input  lpm_state_e state,
    input  logic       ext_prog,
    input  logic       core_ale,
    input  logic       core_psen,
    output pin_ctl_t   pins
);
    always_comb begin
        unique case (state)
            ST_IDLE:             pins = sleep_pins(1'b0, ext_prog);
            ST_PDOWN, ST_SETTLE: pins = sleep_pins(1'b1, ext_prog);
            default: begin
                pins.ale  = core_ale;
                pins.psen = core_psen;
                pins.p0   = PM_CORE;
                pins.p2   = PM_CORE;
                pins.p13  = PM_CORE;
            end
        endcase
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ      = 6,
    parameter int N_EXT      = 2,
    parameter int SETTLE_CYC = 4000,
    parameter int GRACE_CYC  = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_rst,
    input  logic             ctl_we,
    input  logic             ctl_idle_d,
    input  logic             ctl_pd_d,
    output logic             ctl_idle_q,
    output logic             ctl_pd_q,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_EXT-1:0] irq_level,
    input  logic             ext_prog,
    input  logic             core_ale,
    input  logic             core_psen,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             osc_en,
    output logic             core_rst_o,
    output logic             ram_wr_blk,
    output logic             ale_o,
    output logic             psen_o,
    output logic [1:0]       p0_mode,
    output logic [1:0]       p2_mode,
    output logic [1:0]       p13_mode
);
    localparam int CNT_MAX = (SETTLE_CYC > GRACE_CYC) ? SETTLE_CYC : GRACE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] GRACE_LD  = CNT_W'(GRACE_CYC - 1);

    lpm_state_e       st, st_n;
    logic             clr_bits, enter_pd, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             any_wake, ext_wake;
    clk_ctl_t         clks;
    pin_ctl_t         pins;

    lpm_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    lpm_wake #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_wake (
        .clk(clk), .rst(rst), .latch_lvl(enter_pd),
        .irq_pend(irq_pend), .irq_en(irq_en), .irq_level(irq_level),
        .any_wake(any_wake), .ext_wake(ext_wake)
    );

    lpm_pins u_pins (
        .state(st), .ext_prog(ext_prog), .core_ale(core_ale),
        .core_psen(core_psen), .pins(pins)
    );

    always_comb begin
        st_n     = st;
        clr_bits = 1'b0;
        enter_pd = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_RUN: begin
                if (hw_rst) begin
                    clr_bits = 1'b1;
                end else if (ctl_pd_q) begin
                    st_n     = ST_PDOWN;
                    enter_pd = 1'b1;
                end else if (ctl_idle_q) begin
                    st_n = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (hw_rst) begin
                    st_n     = ST_GRACE;
                    tmr_load = 1'b1;
                    tmr_val  = GRACE_LD;
                end else if (any_wake) begin
                    st_n     = ST_RUN;
                    clr_bits = 1'b1;
                end
            end
            ST_GRACE: begin
                if (tmr_done) begin
                    st_n     = ST_RUN;
                    clr_bits = 1'b1;
                end
            end
            ST_PDOWN: begin
                if (hw_rst) begin
                    st_n     = ST_RUN;
                    clr_bits = 1'b1;
                end else if (ext_wake) begin
                    st_n     = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                end
            end
            ST_SETTLE: begin
                if (hw_rst || tmr_done) begin
                    st_n     = ST_RUN;
                    clr_bits = 1'b1;
                end
            end
            default: begin
                st_n     = ST_RUN;
                clr_bits = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= ST_RUN;
        else
            st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_bits) begin
            ctl_idle_q <= 1'b0;
            ctl_pd_q   <= 1'b0;
        end else if (st == ST_RUN && ctl_we && !hw_rst) begin
            ctl_idle_q <= ctl_idle_d;
            ctl_pd_q   <= ctl_pd_d;
        end
    end

    assign clks          = clocks_for(st);
    assign cpu_clk_en    = clks.cpu;
    assign periph_clk_en = clks.periph;
    assign osc_en        = clks.osc;
    assign ram_wr_blk    = (st == ST_GRACE);
    assign core_rst_o    = hw_rst && (st != ST_IDLE) && (st != ST_GRACE);
    assign ale_o         = pins.ale;
    assign psen_o        = pins.psen;
    assign p0_mode       = pins.p0;
    assign p2_mode       = pins.p2;
    assign p13_mode      = pins.p13;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int N_IRQ = 6,
    parameter int N_EXT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             hw_rst,
    input logic             ctl_idle_q,
    input logic             ctl_pd_q,
    input logic [N_IRQ-1:0] irq_pend,
    input logic [N_IRQ-1:0] irq_en,
    input logic             core_ale,
    input logic             core_psen,
    input logic             cpu_clk_en,
    input logic             periph_clk_en,
    input logic             osc_en,
    input logic             core_rst_o,
    input logic             ram_wr_blk,
    input logic             ale_o,
    input logic             psen_o,
    input logic [1:0]       p0_mode,
    input logic [1:0]       p2_mode,
    input logic [1:0]       p13_mode
);
    AST_IDLE_KEEPS_OSC: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && periph_clk_en) |-> (osc_en && ale_o && psen_o)); // R3

    AST_DEEP_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (!cpu_clk_en && !periph_clk_en && !ale_o && !psen_o)); // R5

    AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !hw_rst && ((irq_pend[N_EXT-1:0] & irq_en[N_EXT-1:0]) == '0))
        |=> !osc_en); // R7

    AST_EXIT_CLEARS_REQ: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_clk_en) && !ram_wr_blk) |-> (!ctl_idle_q && !ctl_pd_q)); // R4

    AST_DEEP_RESET_EXIT: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && hw_rst) |=> (osc_en && !ctl_pd_q && !ctl_idle_q)); // R10

    AST_GRACE_RUNS_CORE: assert property (@(posedge clk) disable iff (rst)
        ram_wr_blk |-> (cpu_clk_en && !core_rst_o)); // R9

    AST_RUN_PINS_CORE: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> (ale_o == core_ale && psen_o == core_psen &&
                        p0_mode == 2'd0 && p2_mode == 2'd0 && p13_mode == 2'd0)); // R13
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_chk (
    .clk(clk), .rst(rst), .hw_rst(hw_rst), .ctl_idle_q(ctl_idle_q),
    .ctl_pd_q(ctl_pd_q), .irq_pend(irq_pend), .irq_en(irq_en),
    .core_ale(core_ale), .core_psen(core_psen), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .core_rst_o(core_rst_o),
    .ram_wr_blk(ram_wr_blk), .ale_o(ale_o), .psen_o(psen_o),
    .p0_mode(p0_mode), .p2_mode(p2_mode), .p13_mode(p13_mode)
);

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_ctrl_bench;
    localparam int N_IRQ  = 6;
    localparam int N_EXT  = 2;
    localparam int SETTLE = 20;
    localparam int GRACE  = 6;

    logic clk = 1'b0;
    logic rst, hw_rst, ctl_we, ctl_idle_d, ctl_pd_d, ctl_idle_q, ctl_pd_q;
    logic [N_IRQ-1:0] irq_pend, irq_en;
    logic [N_EXT-1:0] irq_level;
    logic ext_prog, core_ale, core_psen;
    logic cpu_clk_en, periph_clk_en, osc_en, core_rst_o, ram_wr_blk, ale_o, psen_o;
    logic [1:0] p0_mode, p2_mode, p13_mode;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lpm_ctrl #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .SETTLE_CYC(SETTLE), .GRACE_CYC(GRACE)) u_lpm_ctrl (
        .clk(clk), .rst(rst), .hw_rst(hw_rst), .ctl_we(ctl_we), .ctl_idle_d(ctl_idle_d),
        .ctl_pd_d(ctl_pd_d), .ctl_idle_q(ctl_idle_q), .ctl_pd_q(ctl_pd_q),
        .irq_pend(irq_pend), .irq_en(irq_en), .irq_level(irq_level), .ext_prog(ext_prog),
        .core_ale(core_ale), .core_psen(core_psen), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .osc_en(osc_en), .core_rst_o(core_rst_o),
        .ram_wr_blk(ram_wr_blk), .ale_o(ale_o), .psen_o(psen_o),
        .p0_mode(p0_mode), .p2_mode(p2_mode), .p13_mode(p13_mode)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_p0(bit ext);
        return ext ? 2 : 1;
    endfunction

    function automatic int exp_p2(bit deep, bit ext);
        return (ext && !deep) ? 3 : 1;
    endfunction

    task automatic chk_sleep(input bit deep, input bit ext);
        if (deep) begin
            chk("R5 clocks", {cpu_clk_en, periph_clk_en, osc_en}, 0);
            chk("R12 ale/psen", {ale_o, psen_o}, 0);
        end else begin
            chk("R3 clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b011);
            chk("R11 ale/psen", {ale_o, psen_o}, 3);
        end
        chk(deep ? "R12 p0" : "R11 p0", p0_mode, exp_p0(ext));
        chk(deep ? "R12 p2" : "R11 p2", p2_mode, exp_p2(deep, ext));
        chk(deep ? "R12 p13" : "R11 p13", p13_mode, 1);
    endtask

    task automatic enter(input bit i, input bit p);
        ctl_idle_d = i; ctl_pd_d = p; ctl_we = 1'b1;
        tick();
        ctl_we = 1'b0;
        chk("R2 bits", {ctl_idle_q, ctl_pd_q}, {i, p});
        chk("R2 cpu on", cpu_clk_en, 1);
        tick();
    endtask

    task automatic settle_count(input bit ext);
        int n = 0;
        chk("R8 osc back", osc_en, 1);
        chk("R12 settle p0", p0_mode, exp_p0(ext));
        chk("R12 settle ale", ale_o, 0);
        while (!cpu_clk_en && n < 1000) begin
            n++;
            tick();
        end
        chk("R8 settle length", n, SETTLE);
        chk("R8 bits clear", {ctl_idle_q, ctl_pd_q}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit woke, ext, deep;
        int n;
        logic [N_EXT-1:0] lvl;
        void'($urandom(32'd4242));
        rst = 1; hw_rst = 0; ctl_we = 0; ctl_idle_d = 0; ctl_pd_d = 0;
        irq_pend = '0; irq_en = '0; irq_level = '0; ext_prog = 0; core_ale = 0; core_psen = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 clocks", {cpu_clk_en, periph_clk_en, osc_en}, 7);
        chk("R1 bits", {ctl_idle_q, ctl_pd_q}, 0);
        chk("R1 rst/blk", {core_rst_o, ram_wr_blk}, 0);
        chk("R1 modes", {p0_mode, p2_mode, p13_mode}, 0);
        // R13 pass-through
        for (int k = 0; k < 4; k++) begin
            core_ale = $urandom; core_psen = $urandom;
            #1;
            chk("R13 strobes", {ale_o, psen_o}, {core_ale, core_psen});
        end
        // Light sleep, internal memory, disabled pending ignored
        enter(1, 0);
        chk_sleep(0, 0);
        irq_pend = 6'b100000; irq_en = 6'b011111;
        tick();
        chk("R4 disabled ignored", cpu_clk_en, 0);
        irq_en = 6'b100000;
        tick();
        chk("R4 wake", cpu_clk_en, 1);
        chk("R4 bits clear", {ctl_idle_q, ctl_pd_q}, 0);
        irq_pend = '0; irq_en = '0;
        tick();
        // Light sleep, external memory
        ext_prog = 1;
        enter(1, 0);
        chk_sleep(0, 1);
        irq_pend = 6'b000001; irq_en = 6'b000001;
        tick();
        irq_pend = '0; irq_en = '0;
        // Both bits: deep wins; edge-configured at entry stays asleep
        irq_level = 2'b00;
        enter(1, 1);
        chk("R6 deep chosen", osc_en, 0);
        chk_sleep(1, 1);
        irq_level = 2'b11;
        irq_pend = 6'b111111; irq_en = 6'b111111;
        tick();
        chk("R7 edge ignored", osc_en, 0);
        hw_rst = 1;
        tick();
        chk("R10 osc on", osc_en, 1);
        chk("R10 core rst", core_rst_o, 1);
        chk("R10 bits", {ctl_idle_q, ctl_pd_q}, 0);
        hw_rst = 0; irq_pend = '0; irq_en = '0;
        tick();
        // Deep sleep with level line 1; internal line ignored
        ext_prog = 0; irq_level = 2'b10;
        enter(0, 1);
        irq_pend = 6'b000101; irq_en = 6'b000101;
        tick();
        chk("R7 internal/edge ignored", osc_en, 0);
        irq_pend = 6'b000010; irq_en = 6'b000010;
        tick();
        irq_pend = '0; irq_en = '0;
        settle_count(0);
        // Reset pin in light sleep: grace window
        enter(1, 0);
        hw_rst = 1;
        tick();
        n = 0;
        while (ram_wr_blk && n < 100) begin
            chk("R9 cpu in grace", {cpu_clk_en, core_rst_o}, 2);
            n++;
            tick();
        end
        chk("R9 grace length", n, GRACE);
        chk("R9 core rst after", core_rst_o, 1);
        chk("R9 bits", {ctl_idle_q, ctl_pd_q}, 0);
        hw_rst = 0;
        tick();
        // Random phase
        for (int it = 0; it < 80; it++) begin
            int mode;
            ext = $urandom; ext_prog = ext;
            lvl = $urandom; irq_level = lvl;
            mode = $urandom % 3;
            deep = (mode != 0);
            enter(mode != 1, deep);
            chk_sleep(deep, ext);
            if ($urandom % 2) irq_level = ~lvl;
            woke = 0;
            for (int k = 0; k < 4 && !woke; k++) begin
                logic [N_IRQ-1:0] pd, en;
                bit w;
                pd = $urandom; en = $urandom;
                if ($urandom % 2) en = en & pd & 6'b111100;
                irq_pend = pd; irq_en = en;
                w = deep ? |(pd[N_EXT-1:0] & en[N_EXT-1:0] & lvl) : |(pd & en);
                tick();
                irq_pend = '0; irq_en = '0;
                if (w) begin
                    woke = 1;
                    if (deep) settle_count(ext);
                    else begin
                        chk("R4 random wake", cpu_clk_en, 1);
                        chk("R4 random bits", {ctl_idle_q, ctl_pd_q}, 0);
                    end
                end else begin
                    chk(deep ? "R7 random stay" : "R4 random stay",
                        {cpu_clk_en, osc_en}, deep ? 0 : 1);
                end
            end
            if (!woke) begin
                if (deep) begin
                    hw_rst = 1;
                    tick();
                    chk("R10 random exit", {osc_en, core_rst_o}, 3);
                    hw_rst = 0;
                end else begin
                    irq_pend = 6'b001000; irq_en = 6'b001000;
                    tick();
                    chk("R4 random exit", cpu_clk_en, 1);
                    irq_pend = '0; irq_en = '0;
                end
            end
            tick();
            chk("R13 back in run", {p0_mode, p2_mode, p13_mode}, 0);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule